// File: doc/BRIEF.md
# Starvation-Bounded Row-Hit Request Scheduler

This block sits in front of a DRAM channel and decides which pending memory request from several threads is served next. Requests enter a small ordered queue. Each entry records the issuing thread, the target bank and row, and how long it has been waiting. Each time the channel takes a grant, the block selects one entry and reports the estimated service cost. The estimate depends on whether the target bank has the requested row open, has another row open, or has no open row.

Waiting is counted in memory cycles of served work, not in clock cycles. When a request is granted, its service cost is added to the waiting time of every request that stays queued. A request whose waiting time passes a threshold supplied at run time takes precedence over everything else. Without such a request, row-buffer hits are preferred in arrival order. Without a hit, the request that has waited longest is taken. This keeps row locality for throughput and still bounds how long a thread with poor locality can be held back.

Top module: `rhs_sched`

## Requirements
- R1: After reset the queue is empty (`gnt_valid_o` low, `enq_ready_o` high, `full_o` low), and every bank counts as closed, so the first grant to any bank costs T_ACT+T_COL.
- R2: A newly enqueued request starts with a waiting time of zero. Each grant adds the granted cost to the waiting time of every request still queued. Waiting times saturate at 2^WAIT_W-1 rather than wrapping.
- R3: A queued request whose waiting time is strictly greater than `thresh_i` (sampled live each cycle) wins over all others. Among several such requests the largest waiting time wins, and ties go to the earliest arrival.
- R4: With no request over the threshold, a row hit wins. A row hit is a request whose bank is open on the same row. Among several hits the earliest arrival wins.
- R5: With neither an over-threshold request nor a row hit, the request with the largest waiting time wins, and ties go to the earliest arrival.
- R6: `gnt_cost_o` reports the granted request's cost: T_COL for a row hit, T_ACT+T_COL for a closed bank, and T_PRE+T_ACT+T_COL for a bank open on another row (defaults 14, 28, 42).
- R7: After a grant, the granted bank is open on the granted row.
- R8: The queue holds DEPTH requests. When it is full, `full_o` is high and `enq_ready_o` is low. An enqueue offered while the queue is full is dropped and never granted.
- R9: A grant is offered whenever the queue is non-empty. The offered entry is removed only on `gnt_valid_o && gnt_ready_i`, at most one per cycle. An enqueue and a grant in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thresh_i | input | WAIT_W | Waiting-time limit beyond which a request is urgent |
| enq_valid_i | input | 1 | New request offered |
| enq_ready_o | output | 1 | Queue can accept a request |
| enq_tid_i | input | TID_W | Thread id of new request |
| enq_bank_i | input | log2(NBANK) | Bank of new request |
| enq_row_i | input | ROW_W | Row of new request |
| full_o | output | 1 | Queue holds DEPTH requests |
| gnt_valid_o | output | 1 | A request is offered for service |
| gnt_ready_i | input | 1 | Channel takes the offered request |
| gnt_tid_o | output | TID_W | Thread id of offered request |
| gnt_bank_o | output | log2(NBANK) | Bank of offered request |
| gnt_row_o | output | ROW_W | Row of offered request |
| gnt_cost_o | output | COST_W | Service-cost estimate of offered request |

## Verification
Three short streams on one bank check the three cost classes and the hit-before-conflict choice, with all waits tied. A stream of steady hits to one bank holds back a conflicting request until its accumulated waiting passes a threshold of 50. This separates the urgent rule from the row-hit rule. A long run of hits pushes two held-back requests past saturation, and they must then tie and resolve oldest-first, which a wrapping counter would not do. Filling and overfilling the queue, then a long random mix of banks, rows, thresholds and ready patterns, cover the capacity rule and the interplay of all three ordering rules against a behavioural model.

// File: rtl/rhs_pkg.sv
package rhs_pkg;

  // Reason behind the current selection
  typedef enum logic [1:0] {
    PICK_NONE    = 2'd0,
    PICK_AGED    = 2'd1,
    PICK_HIT     = 2'd2,
    PICK_LONGEST = 2'd3
  } pick_why_e;

  // Row-buffer condition seen by a request
  typedef enum logic [1:0] {
    ROW_HIT      = 2'd0,
    ROW_CLOSED   = 2'd1,
    ROW_CONFLICT = 2'd2
  } row_state_e;

endpackage

// File: rtl/rhs_queue.sv
// Arrival-ordered request store: slot 0 is always the oldest entry.
module rhs_queue #(
  parameter int DEPTH  = 8,
  parameter int TID_W  = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int WAIT_W = 10,
  parameter int COST_W = 6,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push_i,
  input  logic [TID_W-1:0]                 push_tid_i,
  input  logic [BANK_W-1:0]                push_bank_i,
  input  logic [ROW_W-1:0]                 push_row_i,
  input  logic                             pop_i,
  input  logic [IDX_W-1:0]                 pop_idx_i,
  input  logic [COST_W-1:0]                pop_cost_i,
  output logic [DEPTH-1:0]                 vld_o,
  output logic [DEPTH-1:0][TID_W-1:0]      tid_o,
  output logic [DEPTH-1:0][BANK_W-1:0]     bank_o,
  output logic [DEPTH-1:0][ROW_W-1:0]      row_o,
  output logic [DEPTH-1:0][WAIT_W-1:0]     wait_o,
  output logic [CNT_W-1:0]                 cnt_o
);

  logic [DEPTH-1:0]             vld_q,  vld_d;
  logic [DEPTH-1:0][TID_W-1:0]  tid_q,  tid_d;
  logic [DEPTH-1:0][BANK_W-1:0] bank_q, bank_d;
  logic [DEPTH-1:0][ROW_W-1:0]  row_q,  row_d;
  logic [DEPTH-1:0][WAIT_W-1:0] wait_q, wait_d;
  logic [CNT_W-1:0]             cnt_q,  cnt_d, cnt_left;
  logic                         upd;

  function automatic logic [WAIT_W-1:0] sat_add(input logic [WAIT_W-1:0] a,
                                                input logic [COST_W-1:0] b);
    logic [WAIT_W:0] s;
    s = {1'b0, a} + (WAIT_W+1)'(b);
    return s[WAIT_W] ? '1 : s[WAIT_W-1:0];
  endfunction

  // Next state: close the gap left by the granted entry, age the
  // survivors by the granted cost, then append the new arrival.
  always_comb begin
    vld_d  = vld_q;
    tid_d  = tid_q;
    bank_d = bank_q;
    row_d  = row_q;
    wait_d = wait_q;
    if (pop_i) begin
      for (int i = 0; i < DEPTH-1; i++) begin
        if (IDX_W'(i) >= pop_idx_i) begin
          vld_d[i]  = vld_q[i+1];
          tid_d[i]  = tid_q[i+1];
          bank_d[i] = bank_q[i+1];
          row_d[i]  = row_q[i+1];
          wait_d[i] = wait_q[i+1];
        end
      end
      vld_d[DEPTH-1] = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        if (vld_d[i]) wait_d[i] = sat_add(wait_d[i], pop_cost_i);
      end
    end
    cnt_left = cnt_q - CNT_W'(pop_i);
    if (push_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == cnt_left) begin
          vld_d[i]  = 1'b1;
          tid_d[i]  = push_tid_i;
          bank_d[i] = push_bank_i;
          row_d[i]  = push_row_i;
          wait_d[i] = '0;
        end
      end
    end
    cnt_d = cnt_left + CNT_W'(push_i);
  end

  assign upd = push_i | pop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      tid_q  <= '0;
      bank_q <= '0;
      row_q  <= '0;
      wait_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      vld_q  <= vld_d;
      tid_q  <= tid_d;
      bank_q <= bank_d;
      row_q  <= row_d;
      wait_q <= wait_d;
      cnt_q  <= cnt_d;
    end
  end

  assign vld_o  = vld_q;
  assign tid_o  = tid_q;
  assign bank_o = bank_q;
  assign row_o  = row_q;
  assign wait_o = wait_q;
  assign cnt_o  = cnt_q;

  // R8: occupancy never passes capacity
  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R8: live slots match the occupancy count
  assert_packed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(cnt_q));

  // R2: a lone arrival lands at the tail with zero waiting time
  assert_fresh_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |=> (wait_q[IDX_W'($past(cnt_q))] == '0));

  // R9: a grant without an arrival removes exactly one entry
  assert_pop_shrink_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rhs_banks.sv
// Per-bank open-row state, per-entry hit detection and cost estimate.
module rhs_banks
  import rhs_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NBANK  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int T_PRE  = 14,
  parameter int T_ACT  = 14,
  parameter int T_COL  = 14,
  parameter int COST_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DEPTH-1:0][BANK_W-1:0] ent_bank_i,
  input  logic [DEPTH-1:0][ROW_W-1:0]  ent_row_i,
  input  logic [BANK_W-1:0]            sel_bank_i,
  input  logic [ROW_W-1:0]             sel_row_i,
  input  logic                         upd_i,
  output logic [DEPTH-1:0]             hit_o,
  output logic [COST_W-1:0]            cost_o
);

  logic [NBANK-1:0]            open_q, open_d;
  logic [NBANK-1:0][ROW_W-1:0] orow_q, orow_d;
  row_state_e                  sel_state;

  // One hit comparator per queue slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign hit_o[g] = open_q[ent_bank_i[g]] &&
                      (orow_q[ent_bank_i[g]] == ent_row_i[g]);
  end

  always_comb begin
    if (!open_q[sel_bank_i])                     sel_state = ROW_CLOSED;
    else if (orow_q[sel_bank_i] == sel_row_i)    sel_state = ROW_HIT;
    else                                         sel_state = ROW_CONFLICT;
  end

  always_comb begin
    case (sel_state)
      ROW_HIT:    cost_o = COST_W'(T_COL);
      ROW_CLOSED: cost_o = COST_W'(T_ACT + T_COL);
      default:    cost_o = COST_W'(T_PRE + T_ACT + T_COL);
    endcase
  end

  always_comb begin
    open_d = open_q;
    orow_d = orow_q;
    if (upd_i) begin
      open_d[sel_bank_i] = 1'b1;
      orow_d[sel_bank_i] = sel_row_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      orow_q <= '0;
    end else if (upd_i) begin
      open_q <= open_d;
      orow_q <= orow_d;
    end
  end

  // R7: granted bank holds the granted row afterwards
  assert_row_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> (open_q[$past(sel_bank_i)] &&
               orow_q[$past(sel_bank_i)] == $past(sel_row_i)));

endmodule

// File: rtl/rhs_pick.sv
// Three-tier selection: urgent, then row hit, then longest wait.
module rhs_pick
  import rhs_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WAIT_W = 10,
  parameter int IDX_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DEPTH-1:0]             vld_i,
  input  logic [DEPTH-1:0][WAIT_W-1:0] wait_i,
  input  logic [DEPTH-1:0]             hit_i,
  input  logic [WAIT_W-1:0]            thresh_i,
  output logic                         sel_vld_o,
  output logic [IDX_W-1:0]             sel_idx_o
);

  logic [DEPTH-1:0]  over;
  logic [IDX_W-1:0]  max_idx, hit_idx;
  logic [WAIT_W-1:0] max_w;
  logic              seen, hit_any;
  pick_why_e         why;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) over[i] = vld_i[i] && (wait_i[i] > thresh_i);
  end

  // Ascending scan with strict compares: the lowest slot wins ties.
  always_comb begin
    max_idx = '0;
    max_w   = '0;
    seen    = 1'b0;
    hit_idx = '0;
    hit_any = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_i[i]) begin
        if (!seen || wait_i[i] > max_w) begin
          max_w   = wait_i[i];
          max_idx = IDX_W'(i);
        end
        seen = 1'b1;
        if (hit_i[i] && !hit_any) begin
          hit_idx = IDX_W'(i);
          hit_any = 1'b1;
        end
      end
    end
  end

  // The urgent winner is the overall longest waiter whenever any is urgent.
  always_comb begin
    if (|over)        why = PICK_AGED;
    else if (hit_any) why = PICK_HIT;
    else if (seen)    why = PICK_LONGEST;
    else              why = PICK_NONE;
    case (why)
      PICK_HIT: sel_idx_o = hit_idx;
      PICK_NONE: sel_idx_o = '0;
      default:  sel_idx_o = max_idx;
    endcase
    sel_vld_o = (why != PICK_NONE);
  end

  // R3: an urgent entry present means an urgent entry is chosen
  assert_aged_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|over) |-> (wait_i[sel_idx_o] > thresh_i));

  // R4: without urgency, a present hit means a hit is chosen
  assert_hit_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vld_o && !(|over) && (|(hit_i & vld_i))) |-> hit_i[sel_idx_o]);

  // R9: the chosen slot always holds a request
  assert_sel_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld_o |-> vld_i[sel_idx_o]);

endmodule

// File: rtl/rhs_sched.sv
module rhs_sched #(
  parameter int DEPTH  = 8,
  parameter int NBANK  = 8,
  parameter int TID_W  = 2,
  parameter int ROW_W  = 14,
  parameter int WAIT_W = 10,
  parameter int T_PRE  = 14,
  parameter int T_ACT  = 14,
  parameter int T_COL  = 14,
  parameter int BANK_W = $clog2(NBANK),
  parameter int COST_W = $clog2(T_PRE + T_ACT + T_COL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] thresh_i,
  input  logic              enq_valid_i,
  output logic              enq_ready_o,
  input  logic [TID_W-1:0]  enq_tid_i,
  input  logic [BANK_W-1:0] enq_bank_i,
  input  logic [ROW_W-1:0]  enq_row_i,
  output logic              full_o,
  output logic              gnt_valid_o,
  input  logic              gnt_ready_i,
  output logic [TID_W-1:0]  gnt_tid_o,
  output logic [BANK_W-1:0] gnt_bank_o,
  output logic [ROW_W-1:0]  gnt_row_o,
  output logic [COST_W-1:0] gnt_cost_o
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]             q_vld, q_hit;
  logic [DEPTH-1:0][TID_W-1:0]  q_tid;
  logic [DEPTH-1:0][BANK_W-1:0] q_bank;
  logic [DEPTH-1:0][ROW_W-1:0]  q_row;
  logic [DEPTH-1:0][WAIT_W-1:0] q_wait;
  logic [CNT_W-1:0]             q_cnt;
  logic [IDX_W-1:0]             sel_idx;
  logic                         sel_vld, enq_fire, gnt_fire;

  assign enq_ready_o = (q_cnt < CNT_W'(DEPTH));
  assign full_o      = (q_cnt == CNT_W'(DEPTH));
  assign enq_fire    = enq_valid_i && enq_ready_o;
  assign gnt_valid_o = sel_vld;
  assign gnt_fire    = gnt_valid_o && gnt_ready_i;
  assign gnt_tid_o   = q_tid[sel_idx];
  assign gnt_bank_o  = q_bank[sel_idx];
  assign gnt_row_o   = q_row[sel_idx];

  rhs_queue #(
    .DEPTH(DEPTH), .TID_W(TID_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .WAIT_W(WAIT_W), .COST_W(COST_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push_i(enq_fire), .push_tid_i(enq_tid_i), .push_bank_i(enq_bank_i),
    .push_row_i(enq_row_i),
    .pop_i(gnt_fire), .pop_idx_i(sel_idx), .pop_cost_i(gnt_cost_o),
    .vld_o(q_vld), .tid_o(q_tid), .bank_o(q_bank), .row_o(q_row),
    .wait_o(q_wait), .cnt_o(q_cnt)
  );

  rhs_banks #(
    .DEPTH(DEPTH), .NBANK(NBANK), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .T_PRE(T_PRE), .T_ACT(T_ACT), .T_COL(T_COL), .COST_W(COST_W)
  ) u_banks (
    .clk(clk), .rst_n(rst_n),
    .ent_bank_i(q_bank), .ent_row_i(q_row),
    .sel_bank_i(gnt_bank_o), .sel_row_i(gnt_row_o), .upd_i(gnt_fire),
    .hit_o(q_hit), .cost_o(gnt_cost_o)
  );

  rhs_pick #(
    .DEPTH(DEPTH), .WAIT_W(WAIT_W), .IDX_W(IDX_W)
  ) u_pick (
    .clk(clk), .rst_n(rst_n),
    .vld_i(q_vld), .wait_i(q_wait), .hit_i(q_hit), .thresh_i(thresh_i),
    .sel_vld_o(sel_vld), .sel_idx_o(sel_idx)
  );

  // R6: re-offering the row just served must be priced as a hit
  assert_repeat_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_fire ##1 (gnt_valid_o && gnt_bank_o == $past(gnt_bank_o) &&
                   gnt_row_o == $past(gnt_row_o)))
    |-> (gnt_cost_o == COST_W'(T_COL)));

  // R6: another row in the bank just served must be priced as a conflict
  assert_other_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_fire ##1 (gnt_valid_o && gnt_bank_o == $past(gnt_bank_o) &&
                   gnt_row_o != $past(gnt_row_o)))
    |-> (gnt_cost_o == COST_W'(T_PRE + T_ACT + T_COL)));

  // R8: a full queue with no grant stays full whatever is offered
  assert_full_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !gnt_fire) |=> full_o);

endmodule

// File: tb/rhs_sched_tb.sv
module rhs_sched_tb;

  localparam int CLK_PERIOD = 10;
  localparam int QD   = 8;
  localparam int WMAX = 1023;
  localparam int TP   = 14;
  localparam int TA   = 14;
  localparam int TC   = 14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  thresh_i;
  logic        enq_valid_i, enq_ready_o, full_o;
  logic [1:0]  enq_tid_i;
  logic [2:0]  enq_bank_i;
  logic [13:0] enq_row_i;
  logic        gnt_valid_o, gnt_ready_i;
  logic [1:0]  gnt_tid_o;
  logic [2:0]  gnt_bank_o;
  logic [13:0] gnt_row_o;
  logic [5:0]  gnt_cost_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  rhs_sched u_dut (
    .clk(clk), .rst_n(rst_n), .thresh_i(thresh_i),
    .enq_valid_i(enq_valid_i), .enq_ready_o(enq_ready_o),
    .enq_tid_i(enq_tid_i), .enq_bank_i(enq_bank_i), .enq_row_i(enq_row_i),
    .full_o(full_o), .gnt_valid_o(gnt_valid_o), .gnt_ready_i(gnt_ready_i),
    .gnt_tid_o(gnt_tid_o), .gnt_bank_o(gnt_bank_o), .gnt_row_o(gnt_row_o),
    .gnt_cost_o(gnt_cost_o)
  );

  // Behavioural reference: arrival-ordered list plus bank table
  int m_cnt;
  int m_tid[QD], m_bank[QD], m_row[QD], m_wait[QD];
  bit m_open[8];
  int m_orow[8];
  int sel_i, sel_why, sel_cost;
  int thr;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // why: 3 urgent (R3), 4 row hit (R4), 5 longest wait (R5)
  function automatic void model_pick();
    int maxw, mi;
    sel_i = -1; sel_why = 0; sel_cost = 0;
    if (m_cnt == 0) return;
    maxw = -1; mi = 0;
    for (int j = 0; j < m_cnt; j++)
      if (m_wait[j] > maxw) begin maxw = m_wait[j]; mi = j; end
    if (maxw > thr) begin sel_i = mi; sel_why = 3; end
    else begin
      for (int j = 0; j < m_cnt; j++)
        if (sel_i < 0 && m_open[m_bank[j]] && m_orow[m_bank[j]] == m_row[j]) begin
          sel_i = j; sel_why = 4;
        end
      if (sel_i < 0) begin sel_i = mi; sel_why = 5; end
    end
    if (!m_open[m_bank[sel_i]])                    sel_cost = TA + TC;
    else if (m_orow[m_bank[sel_i]] == m_row[sel_i]) sel_cost = TC;
    else                                            sel_cost = TP + TA + TC;
  endfunction

  function automatic void model_update(input bit ev, input int tid, input int bk,
                                       input int rw, input bit gr);
    bit room;
    int c;
    room = (m_cnt < QD);
    if (m_cnt > 0 && gr) begin
      c = sel_cost;
      m_open[m_bank[sel_i]] = 1'b1;
      m_orow[m_bank[sel_i]] = m_row[sel_i];
      for (int j = sel_i; j < m_cnt - 1; j++) begin
        m_tid[j] = m_tid[j+1]; m_bank[j] = m_bank[j+1];
        m_row[j] = m_row[j+1]; m_wait[j] = m_wait[j+1];
      end
      m_cnt--;
      for (int j = 0; j < m_cnt; j++)
        m_wait[j] = (m_wait[j] + c > WMAX) ? WMAX : m_wait[j] + c;
    end
    if (ev && room) begin
      m_tid[m_cnt] = tid; m_bank[m_cnt] = bk; m_row[m_cnt] = rw; m_wait[m_cnt] = 0;
      m_cnt++;
    end
  endfunction

  // One clock: drive, compare against the model, then advance the model.
  task automatic step(input bit ev, input int tid, input int bk, input int rw,
                      input bit gr, input int xr = -1, input int xc = -1,
                      input string xreq = "");
    string tag;
    @(negedge clk);
    thresh_i    = thr[9:0];
    enq_valid_i = ev;
    enq_tid_i   = tid[1:0];
    enq_bank_i  = bk[2:0];
    enq_row_i   = rw[13:0];
    gnt_ready_i = gr;
    #1;
    model_pick();
    check(enq_ready_o == (m_cnt < QD), "R8", "enq_ready", enq_ready_o, m_cnt < QD);
    check(full_o == (m_cnt == QD), "R8", "full", full_o, m_cnt == QD);
    check(gnt_valid_o == (m_cnt > 0), "R9", "gnt_valid", gnt_valid_o, m_cnt > 0);
    if (m_cnt > 0) begin
      tag = (sel_why == 3) ? "R3" : (sel_why == 4) ? "R4" : "R5";
      check(int'(gnt_row_o) == m_row[sel_i], tag, "gnt_row", gnt_row_o, m_row[sel_i]);
      check(int'(gnt_bank_o) == m_bank[sel_i], tag, "gnt_bank", gnt_bank_o, m_bank[sel_i]);
      check(int'(gnt_tid_o) == m_tid[sel_i], tag, "gnt_tid", gnt_tid_o, m_tid[sel_i]);
      check(int'(gnt_cost_o) == sel_cost, "R6", "gnt_cost", gnt_cost_o, sel_cost);
    end
    if (xr >= 0) check(gnt_valid_o && int'(gnt_row_o) == xr, xreq, "directed row", gnt_row_o, xr);
    if (xc >= 0) check(int'(gnt_cost_o) == xc, xreq, "directed cost", gnt_cost_o, xc);
    @(posedge clk);
    model_update(ev, tid, bk, rw, gr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_cnt = 0;
    for (int b = 0; b < 8; b++) begin m_open[b] = 1'b0; m_orow[b] = 0; end
    thr = WMAX;
    rst_n = 1'b0; thresh_i = '1; enq_valid_i = 0; enq_tid_i = 0; enq_bank_i = 0;
    enq_row_i = 0; gnt_ready_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1: empty after reset
    check(gnt_valid_o == 1'b0, "R1", "gnt_valid after reset", gnt_valid_o, 0);
    check(enq_ready_o == 1'b1, "R1", "enq_ready after reset", enq_ready_o, 1);
    check(full_o == 1'b0, "R1", "full after reset", full_o, 0);

    // Cost classes on one bank: closed, then hit, then conflict (R1, R7, R6)
    step(1, 0, 0, 1, 0);
    step(1, 1, 0, 2, 0);
    step(1, 2, 0, 1, 0);
    step(0, 0, 0, 0, 1, 1, TA + TC, "R1");
    step(0, 0, 0, 0, 1, 1, TC, "R7");
    step(0, 0, 0, 0, 1, 2, TP + TA + TC, "R6");

    // Capacity: fill, overfill (dropped), then drain (R8)
    for (int k = 0; k < 10; k++) step(1, k % 4, 7, 100 + k, 0);
    for (int k = 0; k < 9; k++) step(0, 0, 0, 0, 1);

    // Urgency overrides hits on bank 3 after waiting passes 50 (R3)
    thr = 50;
    step(1, 0, 3, 1, 0);
    step(1, 0, 3, 1, 0);
    step(1, 0, 3, 1, 0);
    step(1, 1, 3, 9, 1);
    for (int k = 0; k < 6; k++) step(1, 2, 3, 1, 1, (k == 4) ? 9 : -1, (k == 4) ? TP + TA + TC : -1, "R3");
    thr = WMAX;
    for (int k = 0; k < 10; k++) step(0, 0, 0, 0, 1);

    // Saturation: two held-back requests pass the counter limit (R2)
    step(1, 0, 5, 2, 0);
    step(0, 0, 0, 0, 1);
    step(1, 1, 4, 7, 0);
    step(1, 2, 6, 1, 0);
    step(1, 3, 5, 2, 0);
    for (int k = 0; k < 80; k++) step(1, 3, 5, 2, 1);
    thr = 1000;
    step(0, 0, 0, 0, 1, 7, TA + TC, "R2");
    thr = WMAX;
    for (int k = 0; k < 10; k++) step(0, 0, 0, 0, 1);

    // Random mix of banks, rows, thresholds and back-pressure (R3, R4, R5, R9)
    for (int k = 0; k < 3000; k++) begin
      if (k % 200 == 0) begin
        case ($urandom_range(0, 3))
          0: thr = 20;
          1: thr = 50;
          2: thr = 100;
          default: thr = WMAX;
        endcase
      end
      step($urandom_range(0, 9) < 6, $urandom_range(0, 3), $urandom_range(0, 7),
           $urandom_range(0, 3), $urandom_range(0, 9) < 6);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule